// File: doc/BRIEF.md
# Continuous Link Frame Packer

This block sits between a front-end packet formatter and a fixed-width serial link. The formatter hands over one variable-length packet per cycle, made of 1 to `MAX_PKT` bytes. The block keeps these packets in a circular derandomizing store. Once per frame period it emits one 80-bit link frame.

Bytes are packed in arrival order with no gaps and no padding. A packet that does not fit in the remainder of a frame carries on in the next frame. A data frame is emitted only when the store holds enough bytes to fill the whole frame payload. Otherwise a frame with a fixed idle pattern goes out, and the stored bytes wait.

The store has a write pointer, a read pointer and a fill level. It raises `buffer_full` when the free space can no longer absorb the largest packet. A synchronisation strobe throws away everything held and returns both pointers to empty.

There are two ways to separate data frames from idle frames, selected at build time:
- In the default way, `data_valid` is high exactly for data frames.
- In marker mode, `data_valid` stays high all the time, and the top frame bit tells data from idle. This costs payload space: only 9 whole bytes fit per frame instead of 10.

The frame controller is a three-state machine:
- `ST_CLEAR` is entered from reset or a synch strobe and emits idle.
- `ST_IDLE` is entered when fewer than one frame's worth of bytes were held and emits idle.
- `ST_DATA` is entered when a full payload was taken from the store and emits that payload.

On every cycle the machine moves as follows:
- Synch strobe active: go to `ST_CLEAR`.
- Otherwise, at least one payload held: go to `ST_DATA`.
- Otherwise: go to `ST_IDLE`.

Top module: `link_frame_packer`

## Requirements
- R1: During and after reset the block emits idle frames (`frame_out` = `IDLE_PAT`), `data_valid` is low in default mode, and `buffer_full` is low.
- R2: If at a clock edge the store holds at least TAKE bytes (TAKE = 10 in default mode), the frame presented after that edge carries the TAKE oldest bytes. Byte i sits at bits [8i+7:8i], so the oldest byte is at bits [7:0]. `data_valid` is high for that frame. A packet accepted at an edge can be read at the next edge at the earliest.
- R3: Successive packets are packed back to back with no unused bytes between them. A packet is split across frame boundaries wherever the frame ends.
- R4: If at a clock edge the store holds fewer than TAKE bytes, the frame after that edge is exactly `IDLE_PAT` with `data_valid` low, and no stored byte is consumed.
- R5: A packet write (`wr_en` high, `wr_len` bytes in `wr_data`, byte i at bits [8i+7:8i]) is accepted whole when three conditions hold: 1 ≤ `wr_len` ≤ `MAX_PKT`, `wr_len` ≤ `DEPTH` minus the level held at the start of that cycle, and `sync_clr` is low. Otherwise the packet is dropped whole. A read in the same cycle does not make room for that cycle's write.
- R6: `buffer_full` is high exactly when `DEPTH` minus the level held is below `MAX_PKT`.
- R7: At an edge where `sync_clr` is high, all stored bytes and that cycle's write are discarded. The next frame is idle and the store restarts empty.
- R8: With `MARK_MODE` = 1, `data_valid` is always high. Bit 79 is 1 for data and 0 for idle. A data frame carries 9 bytes in bits [71:0] with bits [78:72] zero. An idle frame carries `IDLE_PAT`[78:0] below bit 79.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_clr | input | 1 | Synch strobe: empty the store |
| wr_en | input | 1 | Packet write strobe |
| wr_len | input | $clog2(MAX_PKT+1) | Packet length in bytes |
| wr_data | input | MAX_PKT*WORD_W | Packet bytes, first byte lowest |
| frame_out | output | FRAME_W | Link frame |
| data_valid | output | 1 | Data frame flag (always high in marker mode) |
| buffer_full | output | 1 | Free space below one largest packet |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the defaults (8-bit bytes, 10 bytes per frame, depth 32, packets up to 12 bytes). The other sets marker mode, which leaves 9 bytes per frame. Because the two copies read 9 and 10 bytes per frame, the same packet stream is split at different offsets in each, exercising many split positions. Writing 12-byte packets every cycle outgrows the 10-byte reads by two bytes a cycle. With a depth of 32 this brings both the full flag (level above 20) and whole-packet drops within a dozen cycles.

// File: rtl/lfp_pkg.sv
package lfp_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_DATA  = 2'd2
    } frm_state_e;
endpackage

// File: rtl/lfp_store.sv
module lfp_store #(
    parameter int WORD_W  = 8,
    parameter int DEPTH   = 32,
    parameter int MAX_PKT = 12,
    parameter int TAKE    = 10,
    localparam int AW     = $clog2(DEPTH),
    localparam int LW     = $clog2(MAX_PKT + 1),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      wr_en,
    input  logic [LW-1:0]             wr_len,
    input  logic [MAX_PKT*WORD_W-1:0] wr_data,
    input  logic                      rd_take,
    output logic [TAKE*WORD_W-1:0]    win,
    output logic [CW-1:0]             level,
    output logic                      full
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     free;
    logic              accept;

    always_comb begin
        free   = CW'(DEPTH) - level;
        accept = wr_en && !clr && (wr_len != '0) && (32'(wr_len) <= MAX_PKT)
                 && (CW'(wr_len) <= free);
        full   = free < CW'(MAX_PKT);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_PKT; i++) begin
            if (accept && (i < 32'(wr_len)))
                mem[AW'(32'(wr_ptr) + i)] <= wr_data[i*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (accept)  wr_ptr <= wr_ptr + AW'(wr_len);
            if (rd_take) rd_ptr <= rd_ptr + AW'(TAKE);
            level <= level + (accept ? CW'(wr_len) : CW'(0))
                           - (rd_take ? CW'(TAKE) : CW'(0));
        end
    end

    for (genvar g = 0; g < TAKE; g++) begin : g_win
        assign win[g*WORD_W +: WORD_W] = mem[rd_ptr + AW'(g)];
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH)); // R5

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (level == '0)); // R7

    AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr && (32'(wr_len) > DEPTH - 32'(level)))
        |=> (level == $past(level) - ($past(rd_take) ? CW'(TAKE) : CW'(0)))); // R5
endmodule

// File: rtl/lfp_ctrl.sv
module lfp_ctrl
    import lfp_pkg::*;
#(
    parameter int                  WORD_W    = 8,
    parameter int                  FRAME_W   = 80,
    parameter int                  TAKE      = 10,
    parameter int                  CW        = 6,
    parameter bit                  MARK_MODE = 1'b0,
    parameter logic [FRAME_W-1:0]  IDLE_PAT  = '0,
    localparam int                 PAY_W     = TAKE * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [CW-1:0]      level,
    input  logic [PAY_W-1:0]   win,
    output logic               rd_take,
    output logic [FRAME_W-1:0] frame_out,
    output logic               data_valid
);
    frm_state_e       state;
    frm_state_e       state_nx;
    logic [PAY_W-1:0] pay_q;

    always_comb begin
        rd_take = !clr && (level >= CW'(TAKE));
        if (clr)          state_nx = ST_CLEAR;
        else if (rd_take) state_nx = ST_DATA;
        else              state_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CLEAR;
            pay_q <= '0;
        end else begin
            state <= state_nx;
            if (rd_take) pay_q <= win;
        end
    end

    always_comb begin
        frame_out  = IDLE_PAT;
        data_valid = MARK_MODE;
        unique case (state)
            ST_DATA: begin
                frame_out              = '0;
                frame_out[PAY_W-1:0]   = pay_q;
                data_valid             = 1'b1;
                if (MARK_MODE) frame_out[FRAME_W-1] = 1'b1;
            end
            ST_IDLE, ST_CLEAR: begin
                frame_out  = IDLE_PAT;
                data_valid = MARK_MODE;
                if (MARK_MODE) frame_out[FRAME_W-1] = 1'b0;
            end
            default: begin
                frame_out  = IDLE_PAT;
                data_valid = MARK_MODE;
            end
        endcase
    end

    AST_DATA_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> ($past(level) >= CW'(TAKE))); // R4

    AST_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state == ST_CLEAR)); // R7
endmodule

// File: rtl/link_frame_packer.sv
module link_frame_packer #(
    parameter int                 WORD_W    = 8,
    parameter int                 FRAME_W   = 80,
    parameter int                 DEPTH     = 32,
    parameter int                 MAX_PKT   = 12,
    parameter bit                 MARK_MODE = 1'b0,
    parameter logic [FRAME_W-1:0] IDLE_PAT  = 80'h5C5C_A3A3_5C5C_A3A3_5C5C
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             sync_clr,
    input  logic                             wr_en,
    input  logic [$clog2(MAX_PKT+1)-1:0]     wr_len,
    input  logic [MAX_PKT*WORD_W-1:0]        wr_data,
    output logic [FRAME_W-1:0]               frame_out,
    output logic                             data_valid,
    output logic                             buffer_full
);
    localparam int TAKE = (FRAME_W - int'(MARK_MODE)) / WORD_W;
    localparam int CW   = $clog2(DEPTH + 1);

    logic [TAKE*WORD_W-1:0] win;
    logic [CW-1:0]          level;
    logic                   rd_take;

    lfp_store #(
        .WORD_W(WORD_W), .DEPTH(DEPTH), .MAX_PKT(MAX_PKT), .TAKE(TAKE)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .clr(sync_clr),
        .wr_en(wr_en), .wr_len(wr_len), .wr_data(wr_data),
        .rd_take(rd_take), .win(win), .level(level), .full(buffer_full)
    );

    lfp_ctrl #(
        .WORD_W(WORD_W), .FRAME_W(FRAME_W), .TAKE(TAKE), .CW(CW),
        .MARK_MODE(MARK_MODE), .IDLE_PAT(IDLE_PAT)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .clr(sync_clr),
        .level(level), .win(win), .rd_take(rd_take),
        .frame_out(frame_out), .data_valid(data_valid)
    );
endmodule

// File: tb/link_frame_packer_tb_top.sv
module link_frame_packer_tb_top;
    localparam logic [79:0] IDLE = 80'h5C5C_A3A3_5C5C_A3A3_5C5C;
    localparam int DEPTH = 32;
    localparam int MAXP  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_len = '0;
    logic [95:0] wr_data = '0;
    logic [79:0] fa, fb;
    logic        dva, dvb, fulla, fullb;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit armed = 1'b0;
    string cur_req = "R1";
    logic [7:0] seed = 8'h00;

    logic [7:0]  qa[$];
    logic [7:0]  qb[$];
    logic [79:0] ex_fa, ex_fb;
    logic        ex_dva, ex_dvb, ex_fulla, ex_fullb;

    always #5 clk = ~clk;

    link_frame_packer dut_i (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .wr_en(wr_en),
        .wr_len(wr_len), .wr_data(wr_data),
        .frame_out(fa), .data_valid(dva), .buffer_full(fulla));

    link_frame_packer #(.MARK_MODE(1'b1)) dut_m (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .wr_en(wr_en),
        .wr_len(wr_len), .wr_data(wr_data),
        .frame_out(fb), .data_valid(dvb), .buffer_full(fullb));

    task automatic chk(input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic step(ref logic [7:0] q[$], input int tk, input bit mk,
                        output logic [79:0] f, output logic v, output logic fl);
        int n;
        n = q.size();
        if (sync_clr) begin
            q.delete();
            f = IDLE;
            if (mk) f[79] = 1'b0;
            v = mk;
        end else begin
            if (n >= tk) begin
                f = '0;
                for (int i = 0; i < tk; i++) f[i*8 +: 8] = q.pop_front();
                if (mk) f[79] = 1'b1;
                v = 1'b1;
            end else begin
                f = IDLE;
                if (mk) f[79] = 1'b0;
                v = mk;
            end
            if (wr_en && wr_len >= 1 && int'(wr_len) <= MAXP && int'(wr_len) <= DEPTH - n)
                for (int i = 0; i < int'(wr_len); i++) q.push_back(wr_data[i*8 +: 8]);
        end
        fl = (DEPTH - q.size()) < MAXP;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            qa.delete(); qb.delete();
            ex_fa = IDLE; ex_dva = 1'b0; ex_fulla = 1'b0;
            ex_fb = IDLE; ex_fb[79] = 1'b0; ex_dvb = 1'b1; ex_fullb = 1'b0;
        end else begin
            step(qa, 10, 1'b0, ex_fa, ex_dva, ex_fulla);
            step(qb, 9, 1'b1, ex_fb, ex_dvb, ex_fullb);
        end
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog expired act=%0d exp<=20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            chk(cur_req, "frame A", fa, ex_fa);
            chk(cur_req, "valid A", 80'(dva), 80'(ex_dva));
            chk("R6", "full A", 80'(fulla), 80'(ex_fulla));
            chk(cur_req, "frame B", fb, ex_fb);
            chk("R8", "valid B", 80'(dvb), 80'(ex_dvb));
            chk("R6", "full B", 80'(fullb), 80'(ex_fullb));
        end
    end

    task automatic drive(input int len, input bit en, input bit sy);
        wr_en    = en;
        sync_clr = sy;
        wr_len   = 4'(len);
        wr_data  = {12{8'hEE}};
        for (int i = 0; i < len && i < MAXP; i++) wr_data[i*8 +: 8] = seed + 8'(i);
        if (en) seed = seed + 8'(len);
        @(negedge clk);
        wr_en = 1'b0; sync_clr = 1'b0;
    endtask

    task automatic t_reset;
        cur_req = "R1";
        chk("R1", "reset frame A", fa, IDLE);
        chk("R1", "reset valid A", 80'(dva), 80'd0);
        chk("R1", "reset full A", 80'(fulla), 80'd0);
        chk("R1", "reset frame B top bit", 80'(fb[79]), 80'd0);
        chk("R1", "reset valid B", 80'(dvb), 80'd1);
    endtask

    task automatic t_order;
        cur_req = "R2";
        drive(10, 1'b1, 1'b0);
        chk("R2", "not yet read A", 80'(dva), 80'd0);
        drive(0, 1'b0, 1'b0);
        chk("R2", "byte order A", fa, 80'h09080706050403020100);
        chk("R2", "valid A", 80'(dva), 80'd1);
        chk("R8", "marked frame B", fb, {1'b1, 7'd0, 72'h080706050403020100});
    endtask

    task automatic t_stream;
        cur_req = "R3";
        for (int k = 0; k < 40; k++) drive(1 + (k * 7) % 12, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) drive(0, 1'b0, 1'b0);
    endtask

    task automatic t_idle;
        cur_req = "R4";
        drive(0, 1'b0, 1'b1);
        drive(3, 1'b1, 1'b0);
        drive(0, 1'b0, 1'b0);
        drive(0, 1'b0, 1'b0);
        chk("R4", "idle frame A", fa, IDLE);
        chk("R4", "idle valid A", 80'(dva), 80'd0);
        chk("R8", "idle frame B", fb, {1'b0, IDLE[78:0]});
        drive(7, 1'b1, 1'b0);
        drive(0, 1'b0, 1'b0);
        chk("R4", "held bytes then sent A", 80'(dva), 80'd1);
    endtask

    task automatic t_fill;
        bit seen = 1'b0;
        cur_req = "R5";
        drive(0, 1'b0, 1'b1);
        for (int k = 0; k < 14; k++) begin
            drive(12, 1'b1, 1'b0);
            if (fulla) seen = 1'b1;
        end
        chk("R6", "full flag reached A", 80'(seen), 80'd1);
        drive(0, 1'b1, 1'b0);
        drive(13, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) drive(0, 1'b0, 1'b0);
        chk("R6", "full clear after drain A", 80'(fulla), 80'd0);
    endtask

    task automatic t_sync;
        logic [7:0]  s;
        logic [79:0] e;
        cur_req = "R7";
        drive(8, 1'b1, 1'b0);
        drive(6, 1'b1, 1'b1);
        chk("R7", "idle after sync A", fa, IDLE);
        chk("R7", "full low after sync A", 80'(fulla), 80'd0);
        s = seed;
        drive(10, 1'b1, 1'b0);
        drive(0, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) e[i*8 +: 8] = s + 8'(i);
        chk("R7", "only new bytes A", fa, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        armed = 1'b1;
        @(negedge clk);
        t_order;
        t_stream;
        t_idle;
        t_fill;
        t_sync;
        cur_req = "R8";
        for (int k = 0; k < 20; k++) drive(1 + (k * 5) % 12, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule